// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is the configuration front end of a multi-channel serial I/O controller. A host reaches it through a two-byte window. A byte at offset 0 is a pointer to a register, and a byte at offset 1 carries that register's contents. The port starts out locked. While it is locked, it only watches offset-0 writes for an unlock key. Once unlocked, the host can read fixed identification bytes and pick one of several logical device banks. It can then program each device's 16-bit I/O base address and its RS485 control flags. The contents of every bank are driven continuously on per-device output ports.

A three-state machine controls access. `ST_LOCKED` moves to `ST_KEY_ONE` on an offset-0 write equal to `KEY`. `ST_KEY_ONE` moves to `ST_OPEN` on a second offset-0 write equal to `KEY`. From `ST_KEY_ONE`, any other offset-0 write returns the machine to `ST_LOCKED`. `ST_OPEN` returns to `ST_LOCKED` on an offset-0 write of 0xAA. In `ST_OPEN`, every other offset-0 write loads the register pointer. Offset-1 accesses never move the machine.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset `cfg_open` is low. While locked, `rdata` reads 0xFF and offset-1 writes change no register.
- R2: Two consecutive offset-0 writes of `KEY` raise `cfg_open` after the second write. Offset-1 accesses between the two key writes do not break the sequence.
- R3: While locked, an offset-0 write that differs from `KEY` restarts the sequence. A `KEY` write that follows the mismatch counts as the first key write.
- R4: In the open state, an offset-0 write of 0xAA drops `cfg_open`, after which reads return 0xFF. The register pointer keeps its value across the lock and the next unlock.
- R5: In the open state, register 0x20 reads `CHIP_ID[7:0]`, 0x21 reads `CHIP_ID[15:8]`, 0x23 reads 0x19 and 0x24 reads 0x34.
- R6: Writes to the identification registers are ignored. Reads of any register that is not implemented return 0x00.
- R7: Register 0x07 holds the device selector. A write keeps `wdata[1:0]`, reads return that value zero-extended, and later accesses to 0x60, 0x61 and 0xF0 go to the selected bank.
- R8: In each bank, register 0x61 is the low byte and 0x60 the high byte of the base address. Bank i is driven on `dev_base[16*i+15:16*i]`.
- R9: In each bank, register 0xF0 stores four flags: bit 5 drives `dev_rts_inv`, bit 4 `dev_auto_dir`, bit 3 `dev_rx_wait` and bit 2 `dev_tx_wait`. Other bits read back 0.
- R10: Reset clears the register pointer, the selector and every RS485 byte to zero. Bank i's base address resets to `BASE_DEFAULTS[16*i+15:16*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_off | input | 1 | Window offset: 0 = pointer, 1 = data |
| wr_en | input | 1 | Byte write strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Byte addressed by the pointer (combinational) |
| cfg_open | output | 1 | High while configuration access is unlocked |
| dev_base | output | 16*NUM_DEV | Per-device I/O base addresses |
| dev_rts_inv | output | NUM_DEV | Per-device RTS inversion flag |
| dev_auto_dir | output | NUM_DEV | Per-device RS485 automatic direction enable |
| dev_rx_wait | output | NUM_DEV | Per-device receive-side wait option |
| dev_tx_wait | output | NUM_DEV | Per-device transmit-side wait option |

## Verification
The bench builds the block with `KEY` = 0xA0 and `CHIP_ID` = 0x0501, both values other than the defaults. This shows that the unlock compare and the identification bytes follow the parameters and are not tied to constants. `NUM_DEV` stays at 4 and `BASE_DEFAULTS` keeps its default. Each bank then has a distinct reset address, so a write steered to the wrong bank shows up on the output ports.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED  = 2'd0,
        ST_KEY_ONE = 2'd1,
        ST_OPEN    = 2'd2
    } lock_state_t;

    localparam logic [7:0] EXIT_BYTE   = 8'hAA;
    localparam logic [7:0] LOCKED_READ = 8'hFF;

    localparam logic [7:0] RA_DEV_SEL  = 8'h07;
    localparam logic [7:0] RA_CHIP_LO  = 8'h20;
    localparam logic [7:0] RA_CHIP_HI  = 8'h21;
    localparam logic [7:0] RA_VEND_A   = 8'h23;
    localparam logic [7:0] RA_VEND_B   = 8'h24;
    localparam logic [7:0] RA_BASE_HI  = 8'h60;
    localparam logic [7:0] RA_BASE_LO  = 8'h61;
    localparam logic [7:0] RA_LINE_CTL = 8'hF0;

    localparam logic [7:0] VEND_A_VAL  = 8'h19;
    localparam logic [7:0] VEND_B_VAL  = 8'h34;

    // RS485 flag positions inside the control byte
    localparam int CTL_LSB = 2;
    localparam int CTL_W   = 4;

endpackage

// File: rtl/keyed_cfg_unlock.sv
module keyed_cfg_unlock
    import keyed_cfg_pkg::*;
#(
    parameter logic [7:0] KEY = 8'h87
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ptr_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open,
    output logic       ptr_load
);

    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED:  if (ptr_wr && wdata == KEY) state_d = ST_KEY_ONE;
            ST_KEY_ONE: if (ptr_wr) state_d = (wdata == KEY) ? ST_OPEN : ST_LOCKED;
            ST_OPEN:    if (ptr_wr && wdata == EXIT_BYTE) state_d = ST_LOCKED;
            default:    state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        cfg_open = 1'b0;
        ptr_load = 1'b0;
        unique case (state_q)
            ST_LOCKED, ST_KEY_ONE: cfg_open = 1'b0;
            ST_OPEN: begin
                cfg_open = 1'b1;
                ptr_load = ptr_wr && (wdata != EXIT_BYTE);
            end
            default: cfg_open = 1'b0;
        endcase
    end

endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
    import keyed_cfg_pkg::*;
#(
    parameter logic [15:0] BASE_RST = 16'h03F8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic             ctl_we,
    input  logic [7:0]       wdata,
    output logic [15:0]      base,
    output logic [CTL_W-1:0] ctl
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= BASE_RST;
            ctl  <= '0;
        end else begin
            if (lo_we)  base[7:0]  <= wdata;
            if (hi_we)  base[15:8] <= wdata;
            if (ctl_we) ctl        <= wdata[CTL_LSB +: CTL_W];
        end
    end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import keyed_cfg_pkg::*;
#(
    parameter logic [7:0]  KEY           = 8'h87,
    parameter logic [15:0] CHIP_ID       = 16'h1602,
    parameter int          NUM_DEV       = 4,
    parameter logic [16*NUM_DEV-1:0] BASE_DEFAULTS = 64'h02E8_03E8_02F8_03F8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_off,
    input  logic                  wr_en,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic                  cfg_open,
    output logic [16*NUM_DEV-1:0] dev_base,
    output logic [NUM_DEV-1:0]    dev_rts_inv,
    output logic [NUM_DEV-1:0]    dev_auto_dir,
    output logic [NUM_DEV-1:0]    dev_rx_wait,
    output logic [NUM_DEV-1:0]    dev_tx_wait
);

    localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic             ptr_wr, data_wr, ptr_load;
    logic [7:0]       ptr_q;
    logic [SEL_W-1:0] sel_q;
    logic [15:0]      base_arr [NUM_DEV];
    logic [CTL_W-1:0] ctl_arr  [NUM_DEV];
    logic [15:0]      sel_base;
    logic [CTL_W-1:0] sel_ctl;

    assign ptr_wr  = wr_en && !acc_off;
    assign data_wr = wr_en && acc_off && cfg_open;

    keyed_cfg_unlock #(.KEY(KEY)) unlock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_wr   (ptr_wr),
        .wdata    (wdata),
        .cfg_open (cfg_open),
        .ptr_load (ptr_load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            sel_q <= '0;
        end else begin
            if (ptr_load) ptr_q <= wdata;
            if (data_wr && ptr_q == RA_DEV_SEL) sel_q <= wdata[SEL_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
        logic hit;
        assign hit = data_wr && (sel_q == SEL_W'(g));
        keyed_cfg_bank #(.BASE_RST(BASE_DEFAULTS[16*g +: 16])) bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .lo_we  (hit && ptr_q == RA_BASE_LO),
            .hi_we  (hit && ptr_q == RA_BASE_HI),
            .ctl_we (hit && ptr_q == RA_LINE_CTL),
            .wdata  (wdata),
            .base   (base_arr[g]),
            .ctl    (ctl_arr[g])
        );
        assign dev_base[16*g +: 16] = base_arr[g];
        assign dev_tx_wait[g]  = ctl_arr[g][0];
        assign dev_rx_wait[g]  = ctl_arr[g][1];
        assign dev_auto_dir[g] = ctl_arr[g][2];
        assign dev_rts_inv[g]  = ctl_arr[g][3];
    end

    assign sel_base = base_arr[sel_q];
    assign sel_ctl  = ctl_arr[sel_q];

    always_comb begin
        rdata = 8'h00;
        if (!cfg_open) begin
            rdata = LOCKED_READ;
        end else begin
            case (ptr_q)
                RA_DEV_SEL:  rdata = {{(8-SEL_W){1'b0}}, sel_q};
                RA_CHIP_LO:  rdata = CHIP_ID[7:0];
                RA_CHIP_HI:  rdata = CHIP_ID[15:8];
                RA_VEND_A:   rdata = VEND_A_VAL;
                RA_VEND_B:   rdata = VEND_B_VAL;
                RA_BASE_HI:  rdata = sel_base[15:8];
                RA_BASE_LO:  rdata = sel_base[7:0];
                RA_LINE_CTL: rdata = {2'b00, sel_ctl, 2'b00};
                default:     rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
    parameter logic [7:0] KEY     = 8'h87,
    parameter int         NUM_DEV = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_off,
    input logic                  wr_en,
    input logic [7:0]            wdata,
    input logic [7:0]            rdata,
    input logic                  cfg_open,
    input logic [16*NUM_DEV-1:0] dev_base
);

    a_r1_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> rdata == 8'hFF);

    a_r1_locked_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(dev_base));

    a_r2_open_follows_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(wr_en && !acc_off && wdata == KEY));

    a_r4_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && wr_en && !acc_off && wdata == 8'hAA) |=> !cfg_open);

endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(.KEY(KEY), .NUM_DEV(NUM_DEV)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_off  (acc_off),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .cfg_open (cfg_open),
    .dev_base (dev_base)
);

// File: tb/keyed_cfg_port_tb_top.sv
module keyed_cfg_port_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [7:0]  T_KEY      = 8'hA0;
    localparam logic [15:0] T_CHIP     = 16'h0501;
    localparam int          T_DEV      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_off = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wdata = 8'h00;
    logic [7:0]        rdata;
    logic              cfg_open;
    logic [16*T_DEV-1:0] dev_base;
    logic [T_DEV-1:0]  dev_rts_inv, dev_auto_dir, dev_rx_wait, dev_tx_wait;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_cfg_port #(.KEY(T_KEY), .CHIP_ID(T_CHIP), .NUM_DEV(T_DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_off(acc_off), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .cfg_open(cfg_open), .dev_base(dev_base),
        .dev_rts_inv(dev_rts_inv), .dev_auto_dir(dev_auto_dir),
        .dev_rx_wait(dev_rx_wait), .dev_tx_wait(dev_tx_wait)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic off, input logic [7:0] v);
        @(negedge clk);
        acc_off = off; wr_en = 1'b1; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        acc_off = 1'b1;
        #1 v = rdata;
    endtask

    task automatic unlock();
        wr(1'b0, T_KEY);
        wr(1'b0, T_KEY);
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
        wr(1'b0, a);
        rd(v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 cfg_open after reset", cfg_open, 0);
        rd(v); chk("R1 locked read", v, 8'hFF);
        chk("R10 base defaults", dev_base, 64'h02E8_03E8_02F8_03F8);
        chk("R10 rs485 flags", {dev_rts_inv, dev_auto_dir, dev_rx_wait, dev_tx_wait}, 0);
        unlock();
        rd(v); chk("R10 pointer zero reads reg 0x00", v, 8'h00);
        rd_reg(8'h07, v); chk("R10 selector zero", v, 8'h00);
        wr(1'b0, 8'hAA);
    endtask

    task automatic t_mismatch();
        logic [7:0] v;
        wr(1'b0, T_KEY); wr(1'b0, 8'h55);
        chk("R3 mismatch keeps lock", cfg_open, 0);
        wr(1'b0, T_KEY);
        chk("R3 single key after mismatch", cfg_open, 0);
        wr(1'b0, T_KEY);
        chk("R3 key after mismatch counts first", cfg_open, 1);
        rd(v); chk("R3 open read", v, 8'h00);
        wr(1'b0, 8'hAA);
        wr(1'b0, 8'h87); wr(1'b0, 8'h87);
        chk("R2 other key value rejected", cfg_open, 0);
    endtask

    task automatic t_interleave();
        logic [7:0] v;
        wr(1'b0, T_KEY);
        wr(1'b1, 8'h12);
        rd(v);
        wr(1'b0, T_KEY);
        chk("R2 data access between keys", cfg_open, 1);
        wr(1'b0, 8'hAA);
    endtask

    task automatic t_ids();
        logic [7:0] v;
        unlock();
        rd_reg(8'h20, v); chk("R5 chip id low", v, T_CHIP[7:0]);
        rd_reg(8'h21, v); chk("R5 chip id high", v, T_CHIP[15:8]);
        rd_reg(8'h23, v); chk("R5 vendor byte A", v, 8'h19);
        rd_reg(8'h24, v); chk("R5 vendor byte B", v, 8'h34);
        wr(1'b0, 8'h20); wr(1'b1, 8'h5A); rd(v);
        chk("R6 id write ignored", v, T_CHIP[7:0]);
        wr(1'b0, 8'h30); wr(1'b1, 8'h5A); rd(v);
        chk("R6 unimplemented reads zero", v, 8'h00);
        wr(1'b0, 8'hAA);
    endtask

    task automatic t_banks();
        logic [7:0] v;
        unlock();
        for (int i = 0; i < T_DEV; i++) begin
            wr(1'b0, 8'h07); wr(1'b1, 8'(i));
            wr(1'b0, 8'h61); wr(1'b1, 8'h10 + 8'(i));
            wr(1'b0, 8'h60); wr(1'b1, 8'hC0 + 8'(i));
        end
        chk("R8 bank outputs", dev_base, 64'hC313_C212_C111_C010);
        wr(1'b0, 8'h07); wr(1'b1, 8'h06); rd(v);
        chk("R7 selector keeps two bits", v, 8'h02);
        rd_reg(8'h61, v); chk("R7 selected bank low", v, 8'h12);
        rd_reg(8'h60, v); chk("R8 selected bank high", v, 8'hC2);
        wr(1'b0, 8'hAA);
    endtask

    task automatic t_rs485();
        logic [7:0] v;
        unlock();
        wr(1'b0, 8'h07); wr(1'b1, 8'h01);
        wr(1'b0, 8'hF0); wr(1'b1, 8'hFF);
        rd(v); chk("R9 reserved bits read zero", v, 8'h3C);
        chk("R9 all flags dev1", {dev_rts_inv, dev_auto_dir, dev_rx_wait, dev_tx_wait}, 16'h2222);
        wr(1'b0, 8'h07); wr(1'b1, 8'h03);
        wr(1'b0, 8'hF0); wr(1'b1, 8'h24);
        chk("R9 rts_inv dev3", dev_rts_inv, 4'b1010);
        chk("R9 tx_wait dev3", dev_tx_wait, 4'b1010);
        chk("R9 auto_dir dev3 clear", dev_auto_dir, 4'b0010);
        wr(1'b1, 8'h18);
        chk("R9 auto_dir+rx_wait dev3", {dev_auto_dir, dev_rx_wait, dev_rts_inv}, 12'hAA2);
        wr(1'b0, 8'hAA);
    endtask

    task automatic t_exit();
        logic [7:0] v;
        unlock();
        wr(1'b0, 8'h07); wr(1'b1, 8'h00);
        wr(1'b0, 8'h61);
        wr(1'b0, 8'hAA);
        chk("R4 exit drops open", cfg_open, 0);
        rd(v); chk("R4 read after exit", v, 8'hFF);
        wr(1'b1, 8'h99);
        chk("R1 locked write ignored at port", dev_base[15:0], 16'hC010);
        unlock();
        rd(v); chk("R4 pointer kept across lock", v, 8'h10);
        wr(1'b0, 8'hAA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mismatch();
        t_interleave();
        t_ids();
        t_banks();
        t_rs485();
        t_exit();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule